// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Core

A scalar core that moves one instruction per clock through five stages: fetch, decode with register read, execute, memory access and write-back. Four pipeline registers sit between the stages, so up to five instructions are in flight at once. Instruction memory and data memory are word-addressed arrays inside the core. The program counter counts in words and steps by one.

The environment loads both memories through dedicated write ports while reset is held, then releases reset and waits for `halted_o`. Final state is read through two combinational peek ports, one for the register file and one for data memory. The core has no hazard detection and no forwarding. A program must keep a consumer at least three instruction slots after the instruction that produces its operand. A register written in write-back is seen by decode in the same cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_ni` is low, `halted_o` is 0 and every register reads 0. After reset is released, fetch starts at word 0.
- R2: An instruction word holds opcode in bits [31:29], source A in [28:26], source B in [25:23] and a signed 16-bit offset in [15:0]. ADD (opcode 0) and NAND (opcode 1) write A+B and ~(A&B) to the register named in bits [2:0].
- R3: LW (opcode 2) loads data word (A + sign-extended offset) mod data depth into the register named by field B. SW (opcode 3) stores B's value to that address.
- R4: Register 0 always reads 0, and writes aimed at it are dropped.
- R5: A value written back is visible to an instruction in decode in the same cycle, so a consumer placed three slots after its producer gets the new value.
- R6: BEQ (opcode 4) with A equal to B sets the PC to PC+1+offset. The three instructions after it are discarded. When A and B differ, execution continues in order.
- R7: HALT (opcode 6) raises `halted_o` once it reaches write-back. `halted_o` then stays high and the state no longer changes. No instruction after HALT commits.
- R8: NOP (opcode 7) and the unused opcode 5 change no register and no memory word, whatever their other fields hold.
- R9: With no taken branch, a HALT at word k raises `halted_o` after exactly k+5 rising clock edges following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_addr_i | input | IAW | Instruction memory write address |
| imem_wdata_i | input | 32 | Instruction memory write data |
| dmem_we_i | input | 1 | Data memory load-port write enable |
| dmem_addr_i | input | DAW | Data memory load-port address |
| dmem_wdata_i | input | 32 | Data memory load-port data |
| peek_reg_i | input | 3 | Register index to observe |
| peek_reg_o | output | 32 | Value of the selected register |
| peek_mem_i | input | DAW | Data memory word to observe |
| peek_mem_o | output | 32 | Value of the selected data word |
| halted_o | output | 1 | HALT has reached write-back |

## Verification
Each directed program runs on the core and on a sequential instruction-level model in the bench. All registers and all data words are then compared.

- An ALU-and-load program separates ADD from NAND and the R-type destination from the load destination.
- A store/load program with negative offsets and address wrap checks address arithmetic.
- A program whose consumer sits exactly three slots after its producer succeeds only if decode sees the value written back in the same cycle.
- Taken and untaken branches are placed in front of instructions that would write registers or memory. Their side effects show whether exactly the right three slots were discarded.
- A final program mixes HALT with junk NOP and reserved words and ends with shadow instructions after the HALT. It checks cycle-exact halt timing, that the halted state stays frozen, and that nothing past the HALT commits.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_RSV  = 3'd5,
    OP_HALT = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  localparam logic [XLEN-1:0] NOP_WORD = 32'hE000_0000;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc1;
  } ifid_t;

  typedef struct packed {
    op_e             op;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] pc1;
    logic [RIDX-1:0] dest;
  } idex_t;

  typedef struct packed {
    op_e             op;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] target;
    logic            eq;
    logic [RIDX-1:0] dest;
  } exmem_t;

  typedef struct packed {
    op_e             op;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] ld;
    logic [RIDX-1:0] dest;
  } memwb_t;

  localparam ifid_t  IFID_NOP  = '{instr: NOP_WORD, pc1: '0};
  localparam idex_t  IDEX_NOP  = '{op: OP_NOP, a: '0, b: '0, imm: '0, pc1: '0, dest: '0};
  localparam exmem_t EXMEM_NOP = '{op: OP_NOP, alu: '0, b: '0, target: '0, eq: 1'b0, dest: '0};
  localparam memwb_t MEMWB_NOP = '{op: OP_NOP, alu: '0, ld: '0, dest: '0};

  function automatic logic op_writes_reg(op_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW);
  endfunction

  function automatic logic op_uses_imm(op_e op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  ra_o,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rb_o,
  input  logic [AW-1:0] rp_i,
  output logic [W-1:0]  rp_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs[wa_i] <= wd_i;
    end
  end

  // same-cycle write is visible to readers
  function automatic logic [W-1:0] rd(logic [AW-1:0] a);
    if (a == '0) return '0;
    if (we_i && wa_i == a) return wd_i;
    return regs[a];
  endfunction

  assign ra_o = rd(ra_i);
  assign rb_o = rd(rb_i);
  assign rp_o = rd(rp_i);

  a_r4_r0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni) regs[0] == '0);
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] pc1_i,
  output logic [XLEN-1:0] res_o,
  output logic            eq_o,
  output logic [XLEN-1:0] tgt_o
);
  logic [XLEN-1:0] src2;

  assign src2  = op_uses_imm(op_i) ? imm_i : b_i;
  assign res_o = (op_i == OP_NAND) ? ~(a_i & src2) : a_i + src2;
  assign eq_o  = (a_i == b_i);
  assign tgt_o = pc1_i + imm_i;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_addr_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  input  logic            dmem_we_i,
  input  logic [DAW-1:0]  dmem_addr_i,
  input  logic [XLEN-1:0] dmem_wdata_i,
  input  logic [RIDX-1:0] peek_reg_i,
  output logic [XLEN-1:0] peek_reg_o,
  input  logic [DAW-1:0]  peek_mem_i,
  output logic [XLEN-1:0] peek_mem_o,
  output logic            halted_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [IAW-1:0] pc, pc_inc;
  ifid_t  ifid;
  idex_t  idex, id_next;
  exmem_t exmem, ex_next;
  memwb_t memwb;
  logic   halt_pend, halted_q;

  // fetch
  logic [XLEN-1:0] fetch_word;
  logic take_br, stop_fetch;
  assign fetch_word = imem[pc];
  assign pc_inc     = pc + IAW'(1);
  assign take_br    = (exmem.op == OP_BEQ) && exmem.eq;
  assign stop_fetch = halt_pend | halted_q;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  // decode
  op_e             id_op;
  logic [RIDX-1:0] id_ra, id_rb;
  logic [XLEN-1:0] id_a, id_b;
  logic            wb_we;
  logic [XLEN-1:0] wb_data;

  assign id_op = op_e'(ifid.instr[31:29]);
  assign id_ra = ifid.instr[28:26];
  assign id_rb = ifid.instr[25:23];

  pipe5_regfile #(.NREG(1 << RIDX), .W(XLEN)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (id_ra),
    .ra_o  (id_a),
    .rb_i  (id_rb),
    .rb_o  (id_b),
    .rp_i  (peek_reg_i),
    .rp_o  (peek_reg_o),
    .we_i  (wb_we),
    .wa_i  (memwb.dest),
    .wd_i  (wb_data)
  );

  always_comb begin
    id_next.op   = (id_op == OP_RSV) ? OP_NOP : id_op;
    id_next.a    = id_a;
    id_next.b    = id_b;
    id_next.imm  = {{(XLEN-16){ifid.instr[15]}}, ifid.instr[15:0]};
    id_next.pc1  = ifid.pc1;
    id_next.dest = (id_op == OP_LW) ? id_rb : ifid.instr[RIDX-1:0];
  end

  // execute
  logic [XLEN-1:0] ex_res, ex_tgt;
  logic            ex_eq;

  pipe5_alu u_alu (
    .op_i (idex.op),
    .a_i  (idex.a),
    .b_i  (idex.b),
    .imm_i(idex.imm),
    .pc1_i(idex.pc1),
    .res_o(ex_res),
    .eq_o (ex_eq),
    .tgt_o(ex_tgt)
  );

  always_comb begin
    ex_next.op     = idex.op;
    ex_next.alu    = ex_res;
    ex_next.b      = idex.b;
    ex_next.target = ex_tgt;
    ex_next.eq     = ex_eq;
    ex_next.dest   = idex.dest;
  end

  // memory
  logic [DAW-1:0]  mem_addr;
  logic [XLEN-1:0] mem_rdata;
  assign mem_addr   = exmem.alu[DAW-1:0];
  assign mem_rdata  = dmem[mem_addr];
  assign peek_mem_o = dmem[peek_mem_i];

  always_ff @(posedge clk_i) begin
    if (dmem_we_i)               dmem[dmem_addr_i] <= dmem_wdata_i;
    else if (exmem.op == OP_SW)  dmem[mem_addr]    <= exmem.b;
  end

  // write-back
  assign wb_we    = op_writes_reg(memwb.op);
  assign wb_data  = (memwb.op == OP_LW) ? memwb.ld : memwb.alu;
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc        <= '0;
      ifid      <= IFID_NOP;
      idex      <= IDEX_NOP;
      exmem     <= EXMEM_NOP;
      memwb     <= MEMWB_NOP;
      halt_pend <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      halted_q <= halted_q | (memwb.op == OP_HALT);
      memwb    <= '{op: exmem.op, alu: exmem.alu, ld: mem_rdata, dest: exmem.dest};
      if (take_br) begin
        pc        <= exmem.target[IAW-1:0];
        ifid      <= IFID_NOP;
        idex      <= IDEX_NOP;
        exmem     <= EXMEM_NOP;
        halt_pend <= 1'b0;
      end else begin
        exmem <= ex_next;
        if (stop_fetch) begin
          ifid <= IFID_NOP;
          idex <= IDEX_NOP;
        end else begin
          pc        <= pc_inc;
          ifid      <= '{instr: fetch_word, pc1: XLEN'(pc_inc)};
          idex      <= id_next;
          halt_pend <= (id_op == OP_HALT);
        end
      end
    end
  end

  a_r6_flush_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_br |=> (ifid.instr == NOP_WORD && idex.op == OP_NOP && exmem.op == OP_NOP));
  a_r6_branch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_br |=> pc == $past(exmem.target[IAW-1:0]));
  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  a_r7_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> $stable(pc));
  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_br && !stop_fetch) |=> pc == $past(pc) + IAW'(1));
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam logic [2:0] O_ADD = 3'd0, O_NAND = 3'd1, O_LW = 3'd2, O_SW = 3'd3,
                         O_BEQ = 3'd4, O_HALT = 3'd6, O_NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0, dmem_we = 1'b0;
  logic [5:0]  imem_addr = '0, dmem_addr = '0, peek_mem = '0;
  logic [31:0] imem_wdata = '0, dmem_wdata = '0;
  logic [2:0]  peek_reg = '0;
  logic [31:0] peek_reg_v, peek_mem_v;
  logic        halted;

  int total = 0;
  int bad = 0;

  logic [31:0] prog [IW];
  logic [31:0] dinit [DW];
  logic [31:0] ref_rf [8];
  logic [31:0] ref_dm [DW];

  always #10 clk = ~clk;

  pipe5_core dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_we_i(imem_we), .imem_addr_i(imem_addr), .imem_wdata_i(imem_wdata),
    .dmem_we_i(dmem_we), .dmem_addr_i(dmem_addr), .dmem_wdata_i(dmem_wdata),
    .peek_reg_i(peek_reg), .peek_reg_o(peek_reg_v),
    .peek_mem_i(peek_mem), .peek_mem_o(peek_mem_v),
    .halted_o(halted)
  );

  function automatic logic [31:0] enc_r(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] d);
    return {op, a, b, 20'd0, d};
  endfunction
  function automatic logic [31:0] enc_i(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [15:0] off);
    return {op, a, b, 7'd0, off};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < IW; i++) prog[i] = enc_r(O_NOP, 0, 0, 0);
    for (int i = 0; i < DW; i++) dinit[i] = '0;
  endtask

  // sequential instruction-level model
  task automatic run_ref();
    int pc = 0;
    for (int i = 0; i < 8; i++) ref_rf[i] = '0;
    for (int i = 0; i < DW; i++) ref_dm[i] = dinit[i];
    for (int s = 0; s < 2000; s++) begin
      logic [31:0] w, a, b, imm;
      logic [2:0]  op;
      logic [5:0]  ad;
      w = prog[pc];
      op = w[31:29];
      a = ref_rf[w[28:26]];
      b = ref_rf[w[25:23]];
      imm = {{16{w[15]}}, w[15:0]};
      ad = 6'(a + imm);
      if (op == O_HALT) break;
      case (op)
        O_ADD:  ref_rf[w[2:0]] = a + b;
        O_NAND: ref_rf[w[2:0]] = ~(a & b);
        O_LW:   ref_rf[w[25:23]] = ref_dm[ad];
        O_SW:   ref_dm[ad] = b;
        default: ;
      endcase
      ref_rf[0] = '0;
      if (op == O_BEQ && a == b) pc = 6'(pc + 1 + int'(imm));
      else pc = (pc + 1) % IW;
    end
  endtask

  task automatic run_dut(string tag, output int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 6'(i); imem_wdata = prog[i];
      dmem_we = 1'b1; dmem_addr = 6'(i); dmem_wdata = dinit[i];
    end
    @(negedge clk);
    imem_we = 1'b0; dmem_we = 1'b0;
    rst_n = 1'b1;
    cycles = 0;
    while (!halted && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
    if (!halted) chk({tag, " halt timeout"}, 32'(halted), 32'd1);
  endtask

  task automatic compare_state(string tag);
    run_ref();
    for (int r = 0; r < 8; r++) begin
      peek_reg = 3'(r); #1;
      chk($sformatf("%s reg%0d", tag, r), peek_reg_v, ref_rf[r]);
    end
    for (int m = 0; m < DW; m++) begin
      peek_mem = 6'(m); #1;
      chk($sformatf("%s mem%0d", tag, m), peek_mem_v, ref_dm[m]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 halted in reset", 32'(halted), 32'd0);
    for (int r = 0; r < 8; r++) begin
      peek_reg = 3'(r); #1;
      chk("R1 reg zero in reset", peek_reg_v, 32'd0);
    end
  endtask

  task automatic t_alu();
    int cyc;
    clear_all();
    dinit[0] = 32'd5; dinit[1] = 32'd9; dinit[2] = 32'hF0F0_1234;
    prog[0] = enc_i(O_LW, 0, 1, 16'd0);
    prog[1] = enc_i(O_LW, 0, 2, 16'd1);
    prog[2] = enc_i(O_LW, 0, 3, 16'd2);
    prog[5] = enc_r(O_ADD, 1, 2, 4);
    prog[6] = enc_r(O_NAND, 2, 3, 5);
    prog[7] = enc_r(O_ADD, 1, 3, 6);
    prog[8] = enc_r(O_NAND, 4, 4, 7);
    prog[9] = enc_i(O_SW, 0, 4, 16'd10);
    prog[10] = enc_r(O_HALT, 0, 0, 0);
    run_dut("R2", cyc);
    compare_state("R2 alu");
  endtask

  task automatic t_mem();
    int cyc;
    clear_all();
    dinit[0] = 32'd20; dinit[1] = 32'hABCD_0001;
    prog[0] = enc_i(O_LW, 0, 1, 16'd0);
    prog[1] = enc_i(O_LW, 0, 2, 16'd1);
    prog[4] = enc_i(O_SW, 1, 2, 16'hFFFD);
    prog[5] = enc_i(O_SW, 1, 2, 16'd5);
    prog[6] = enc_i(O_LW, 1, 3, 16'hFFED);
    prog[7] = enc_i(O_LW, 1, 4, 16'hFFFD);
    prog[8] = enc_i(O_SW, 0, 2, 16'hFFFF);
    prog[9] = enc_r(O_HALT, 0, 0, 0);
    run_dut("R3", cyc);
    compare_state("R3 ldst");
  endtask

  task automatic t_bypass();
    int cyc;
    clear_all();
    dinit[0] = 32'd7;
    prog[0] = enc_i(O_LW, 0, 1, 16'd0);
    prog[3] = enc_r(O_ADD, 1, 1, 2);
    prog[6] = enc_r(O_ADD, 2, 1, 3);
    prog[9] = enc_i(O_SW, 0, 3, 16'd8);
    prog[10] = enc_r(O_HALT, 0, 0, 0);
    run_dut("R5", cyc);
    peek_reg = 3'd2; #1;
    chk("R5 gap-three consumer", peek_reg_v, 32'd14);
    compare_state("R5 bypass");
  endtask

  task automatic t_r0();
    int cyc;
    clear_all();
    dinit[0] = 32'd99; dinit[1] = 32'd3;
    prog[0] = enc_i(O_LW, 0, 0, 16'd0);
    prog[1] = enc_i(O_LW, 0, 1, 16'd1);
    prog[4] = enc_r(O_ADD, 1, 1, 0);
    prog[7] = enc_r(O_ADD, 0, 1, 2);
    prog[8] = enc_r(O_HALT, 0, 0, 0);
    run_dut("R4", cyc);
    peek_reg = 3'd0; #1;
    chk("R4 r0 stays zero", peek_reg_v, 32'd0);
    compare_state("R4 r0");
  endtask

  task automatic t_branch();
    int cyc;
    clear_all();
    dinit[0] = 32'd4; dinit[1] = 32'd4; dinit[2] = 32'd6;
    prog[0] = enc_i(O_LW, 0, 1, 16'd0);
    prog[1] = enc_i(O_LW, 0, 2, 16'd1);
    prog[2] = enc_i(O_LW, 0, 3, 16'd2);
    prog[5] = enc_i(O_BEQ, 1, 2, 16'd4);
    prog[6] = enc_r(O_ADD, 1, 1, 7);
    prog[7] = enc_i(O_SW, 0, 1, 16'd30);
    prog[8] = enc_r(O_ADD, 1, 3, 7);
    prog[9] = enc_r(O_ADD, 3, 3, 7);
    prog[10] = enc_i(O_BEQ, 1, 3, 16'd2);
    prog[11] = enc_r(O_ADD, 1, 3, 4);
    prog[12] = enc_r(O_NAND, 1, 3, 5);
    prog[13] = enc_i(O_BEQ, 0, 0, 16'd3);
    prog[14] = enc_r(O_ADD, 1, 1, 7);
    prog[15] = enc_i(O_SW, 0, 1, 16'd31);
    prog[16] = enc_r(O_ADD, 3, 1, 7);
    prog[17] = enc_r(O_ADD, 2, 3, 6);
    prog[18] = enc_r(O_HALT, 0, 0, 0);
    run_dut("R6", cyc);
    peek_reg = 3'd7; #1;
    chk("R6 discarded slots did not write", peek_reg_v, 32'd0);
    peek_reg = 3'd4; #1;
    chk("R6 untaken branch falls through", peek_reg_v, 32'd10);
    compare_state("R6 branch");
  endtask

  task automatic t_halt();
    int cyc;
    clear_all();
    dinit[0] = 32'd11;
    prog[0] = enc_i(O_LW, 0, 1, 16'd0);
    prog[1] = enc_r(O_NOP, 1, 1, 1);
    prog[2] = 32'hBFFF_FFFF;
    prog[3] = enc_r(O_ADD, 1, 1, 2);
    prog[4] = enc_i(O_NOP, 1, 1, 16'h0005);
    prog[5] = enc_r(O_HALT, 0, 0, 0);
    prog[6] = enc_r(O_ADD, 1, 1, 3);
    prog[7] = enc_i(O_SW, 0, 1, 16'd5);
    prog[8] = enc_r(O_ADD, 1, 1, 4);
    run_dut("R9", cyc);
    chk("R9 halt latency k+5", 32'(cyc), 32'd10);
    compare_state("R8 nop/reserved, R7 shadow");
    repeat (6) @(negedge clk);
    chk("R7 halted stays high", 32'(halted), 32'd1);
    compare_state("R7 frozen");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL all watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_bypass();
    t_r0();
    t_branch();
    t_halt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule